// File: doc/BRIEF.md
# Teletext page request matcher

This block keeps the page requests of eight acquisition slots and compares every decoded page header against all of them in parallel. A request is seven short columns: magazine with a hold flag, page tens, page units, and four subcode digits (hours tens and units, minutes tens and units). Each column carries its own care flag. One request can therefore ask for any version of a page or for one timed subcode only.

Requests are loaded one column per write. A start column is loaded first. Each accepted write then moves the column pointer forward. The target slot is named by a group bit and a two-bit index inside that group. One cycle after a header is presented, the block reports whether a slot matched, which slot it was (the lowest number wins), and whether capture should go ahead. Capture is withheld when the reported slot is held. Every slot also keeps an active-low found flag. A header match pulls the flag low, and an accepted write to the slot raises it again.

Hamming decoding of the header, and writing page rows into memory, are done by neighbouring logic. That logic supplies one error flag per header field.

Top module: `ttx_page_matcher`

## Requirements
- R1: After reset, `found_n` is all ones and `found_pulse` and `capture` are 0. All request columns are 0, so every field is "don't care" and every slot is held.
- R2: A write with `col_load` high goes to column `col_start`. A write without it goes to the current pointer. Each accepted write sets the pointer to the written column plus one. When the pointer reaches 7 it stays there, and writes are dropped until the next `col_load`.
- R3: A field takes part in the compare only when bit 4 of its column is 1. A field whose bit 4 is 0 always matches. A slot matches when all seven of its fields match.
- R4: Only the low bits of each column are compared: magazine 3 bits, page tens 4, page units 4, hours tens 2, hours units 4, minutes tens 3, minutes units 4. Bit 3 of column 0 is the hold flag and is never compared.
- R5: `hdr_err` bit i flags a Hamming error in the field of column i (bit 0 is the magazine, bit 6 is minutes units). An error in a cared field prevents a match. An error in a don't-care field has no effect.
- R6: One cycle after a header with at least one matching slot, `found_pulse` is 1 and `found_slot` gives the lowest-numbered matching slot.
- R7: `capture` is 1 only together with `found_pulse`, and only when the hold bit (column 0 bit 3) of the reported slot is 1. A hold bit of 0 holds the page: the slot is found but not captured.
- R8: Each matching slot's `found_n` bit goes low one cycle after the header. An accepted write to a slot sets its bit high. A slot written in the same cycle as a header is left out of that header's match.
- R9: The slot number is {`wr_group`, `wr_quad`}, so group 1, index 1 is slot 5.
- R10: Without `hdr_valid`, `found_pulse` stays 0 and no found flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| col_load | input | 1 | Load the column pointer from `col_start` |
| col_start | input | 3 | Start column for the next write |
| wr_en | input | 1 | Write one request column |
| wr_group | input | 1 | Slot group select |
| wr_quad | input | 2 | Slot index within the group |
| wr_data | input | 5 | Column value, bit 4 = care |
| hdr_valid | input | 1 | Decoded header present this cycle |
| hdr_mag | input | 3 | Header magazine |
| hdr_tens | input | 4 | Header page tens |
| hdr_units | input | 4 | Header page units |
| hdr_hr_tens | input | 2 | Header hours tens |
| hdr_hr_units | input | 4 | Header hours units |
| hdr_min_tens | input | 3 | Header minutes tens |
| hdr_min_units | input | 4 | Header minutes units |
| hdr_err | input | 7 | Per-field Hamming error flags |
| found_pulse | output | 1 | A slot matched the last header |
| found_slot | output | 3 | Lowest matching slot |
| capture | output | 1 | Matched slot is not held |
| found_n | output | 8 | Per-slot found flags, active low |

## Verification
A request write and a header match can fall in the same cycle on the same slot. The write raises that slot's found flag, and the match would pull the same flag low. The bench first lets a header find slot 3, so the flag is low. It then rewrites slot 3 in the very cycle a matching header arrives. Correct behaviour is no found pulse and the flag of slot 3 back high. A wildcard slot, a dropped write at the end of a request and held slots cover the neighbouring orderings.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;
  localparam int REQ_COLS = 7;
  localparam int REQ_W    = 5;
  localparam int NIB_W    = 4;
  localparam int PTR_W    = $clog2(REQ_COLS + 1);

  // bits of each column that carry the field value
  function automatic logic [NIB_W-1:0] col_mask(input int col);
    case (col)
      0:       return 4'h7;
      3:       return 4'h3;
      5:       return 4'h7;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic field_ok(input logic [REQ_W-1:0] req,
                                    input logic [NIB_W-1:0] got,
                                    input logic             err,
                                    input logic [NIB_W-1:0] mask);
    return !req[REQ_W-1] || (!err && (((req[NIB_W-1:0] ^ got) & mask) == '0));
  endfunction
endpackage

// File: rtl/ttx_req_store.sv
module ttx_req_store
  import ttx_req_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  col_load,
  input  logic [PTR_W-1:0]                      col_start,
  input  logic                                  wr_en,
  input  logic [SLOT_W-1:0]                     wr_slot,
  input  logic [REQ_W-1:0]                      wr_data,
  output logic [NUM_SLOTS*REQ_COLS*REQ_W-1:0]   req_flat,
  output logic [NUM_SLOTS-1:0]                  hold_o,
  output logic [NUM_SLOTS-1:0]                  wr_touch
);
  localparam logic [PTR_W-1:0] PARK = PTR_W'(REQ_COLS);

  logic [REQ_W-1:0] mem_q [NUM_SLOTS][REQ_COLS];
  logic [PTR_W-1:0] ptr_q, ptr_d, tgt_col;
  logic             accept;

  always_comb begin
    tgt_col = col_load ? col_start : ptr_q;
    accept  = wr_en && (tgt_col < PARK);
    ptr_d   = ptr_q;
    if (col_load) ptr_d = col_start;
    if (accept)   ptr_d = tgt_col + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int c = 0; c < REQ_COLS; c++)
          mem_q[s][c] <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (accept) mem_q[wr_slot][tgt_col] <= wr_data;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign wr_touch[s] = accept && (wr_slot == SLOT_W'(s));
    assign hold_o[s]   = mem_q[s][0][3];
    for (genvar c = 0; c < REQ_COLS; c++) begin : g_col
      assign req_flat[(s*REQ_COLS+c)*REQ_W +: REQ_W] = mem_q[s][c];
    end
  end

  p_ptr_parks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_load && ptr_q == PARK) |=> (ptr_q == PARK));
  p_ptr_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !col_load && ptr_q < PARK) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));
  p_parked_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_load && ptr_q == PARK) |-> (wr_touch == '0));
endmodule

// File: rtl/ttx_slot_cmp.sv
module ttx_slot_cmp
  import ttx_req_pkg::*;
(
  input  logic [REQ_COLS*REQ_W-1:0] req,
  input  logic [REQ_COLS*NIB_W-1:0] hdr_nib,
  input  logic [REQ_COLS-1:0]       hdr_err,
  input  logic                      blocked,
  output logic                      hit
);
  logic [REQ_COLS-1:0] col_ok;

  for (genvar c = 0; c < REQ_COLS; c++) begin : g_col
    assign col_ok[c] = field_ok(req[c*REQ_W +: REQ_W], hdr_nib[c*NIB_W +: NIB_W],
                                hdr_err[c], col_mask(c));
  end

  assign hit = (&col_ok) && !blocked;

  always_comb begin
    if (req[REQ_W-1] && hdr_err[0])
      p_err_blocks_mag_r5: assert (!hit);
  end
endmodule

// File: rtl/ttx_prio_pick.sv
module ttx_prio_pick #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] hits,
  output logic                 any_hit,
  output logic [SLOT_W-1:0]    idx
);
  logic [NUM_SLOTS-1:0] below;

  always_comb begin
    any_hit = |hits;
    idx     = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (hits[s]) idx = SLOT_W'(s);
  end

  always_comb begin
    below = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      below[s] = (SLOT_W'(s) < idx);
    if (any_hit)
      p_lowest_wins_r6: assert (hits[idx] && ((hits & below) == '0));
  end
endmodule

// File: rtl/ttx_page_matcher.sv
module ttx_page_matcher
  import ttx_req_pkg::*;
#(
  parameter int GROUPS    = 2,
  parameter int QUAD      = 4,
  parameter int NUM_SLOTS = GROUPS * QUAD,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int GRP_W     = $clog2(GROUPS),
  parameter int SUB_W     = $clog2(QUAD)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 col_load,
  input  logic [PTR_W-1:0]     col_start,
  input  logic                 wr_en,
  input  logic [GRP_W-1:0]     wr_group,
  input  logic [SUB_W-1:0]     wr_quad,
  input  logic [REQ_W-1:0]     wr_data,
  input  logic                 hdr_valid,
  input  logic [2:0]           hdr_mag,
  input  logic [3:0]           hdr_tens,
  input  logic [3:0]           hdr_units,
  input  logic [1:0]           hdr_hr_tens,
  input  logic [3:0]           hdr_hr_units,
  input  logic [2:0]           hdr_min_tens,
  input  logic [3:0]           hdr_min_units,
  input  logic [REQ_COLS-1:0]  hdr_err,
  output logic                 found_pulse,
  output logic [SLOT_W-1:0]    found_slot,
  output logic                 capture,
  output logic [NUM_SLOTS-1:0] found_n
);
  localparam int ROW_W = REQ_COLS * REQ_W;

  logic [NUM_SLOTS*ROW_W-1:0] req_flat;
  logic [NUM_SLOTS-1:0]       hold_v, wr_touch, hits_raw, hits_v;
  logic [REQ_COLS*NIB_W-1:0]  hdr_nib;
  logic                       any_hit;
  logic [SLOT_W-1:0]          pick_idx;

  assign hdr_nib = {hdr_min_units, 1'b0, hdr_min_tens, hdr_hr_units, 2'b00, hdr_hr_tens,
                    hdr_units, hdr_tens, 1'b0, hdr_mag};

  ttx_req_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_load (col_load),
    .col_start(col_start),
    .wr_en    (wr_en),
    .wr_slot  ({wr_group, wr_quad}),
    .wr_data  (wr_data),
    .req_flat (req_flat),
    .hold_o   (hold_v),
    .wr_touch (wr_touch)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    ttx_slot_cmp u_cmp (
      .req    (req_flat[s*ROW_W +: ROW_W]),
      .hdr_nib(hdr_nib),
      .hdr_err(hdr_err),
      .blocked(wr_touch[s]),
      .hit    (hits_raw[s])
    );
  end

  assign hits_v = hits_raw & {NUM_SLOTS{hdr_valid}};

  ttx_prio_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .hits   (hits_v),
    .any_hit(any_hit),
    .idx    (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_pulse <= 1'b0;
      found_slot  <= '0;
      capture     <= 1'b0;
      found_n     <= '1;
    end else begin
      found_pulse <= any_hit;
      if (any_hit) found_slot <= pick_idx;
      capture     <= any_hit && hold_v[pick_idx];
      found_n     <= (found_n | wr_touch) & ~hits_v;
    end
  end

  p_capture_implies_found_r7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> found_pulse);
  p_quiet_without_header_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !found_pulse);
  p_reported_flag_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    found_pulse |-> !found_n[found_slot]);
  p_flags_steady_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_valid && wr_touch == '0) |=> $stable(found_n));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    p_write_raises_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_touch[s] |=> found_n[s]);
  end
endmodule

// File: tb/ttx_page_matcher_tb.sv
module ttx_page_matcher_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic col_load = 0, wr_en = 0, hdr_valid = 0;
  logic [2:0] col_start = 0;
  logic [0:0] wr_group = 0;
  logic [1:0] wr_quad = 0;
  logic [4:0] wr_data = 0;
  logic [2:0] hdr_mag = 0, hdr_min_tens = 0;
  logic [3:0] hdr_tens = 0, hdr_units = 0, hdr_hr_units = 0, hdr_min_units = 0;
  logic [1:0] hdr_hr_tens = 0;
  logic [6:0] hdr_err = 0;
  logic       found_pulse, capture;
  logic [2:0] found_slot;
  logic [7:0] found_n;

  int n_chk = 0, n_bad = 0;
  int bptr = 0;
  logic [7:0] exp_fn = 8'hFF;
  logic [7:0] hold_m = 8'h00;

  always #2 clk = ~clk;

  ttx_page_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .col_load(col_load), .col_start(col_start),
    .wr_en(wr_en), .wr_group(wr_group), .wr_quad(wr_quad), .wr_data(wr_data),
    .hdr_valid(hdr_valid), .hdr_mag(hdr_mag), .hdr_tens(hdr_tens),
    .hdr_units(hdr_units), .hdr_hr_tens(hdr_hr_tens), .hdr_hr_units(hdr_hr_units),
    .hdr_min_tens(hdr_min_tens), .hdr_min_units(hdr_min_units), .hdr_err(hdr_err),
    .found_pulse(found_pulse), .found_slot(found_slot), .capture(capture),
    .found_n(found_n)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    col_load = 0; wr_en = 0; hdr_valid = 0; hdr_err = '0;
  endtask

  task automatic set_wr(input int sl, input int st, input logic [4:0] d);
    int col;
    col_load  = (st >= 0);
    col_start = 3'(st < 0 ? 0 : st);
    wr_en     = 1;
    wr_group  = 1'(sl / 4);
    wr_quad   = 2'(sl % 4);
    wr_data   = d;
    col = (st >= 0) ? st : bptr;
    if (col < 7) begin
      bptr = col + 1;
      exp_fn[sl] = 1'b1;
      if (col == 0) hold_m[sl] = d[3];
    end else bptr = 7;
  endtask

  task automatic set_hdr(input int mg, pt, pu, ht, hu, mt, mu, input logic [6:0] er);
    hdr_valid = 1;
    hdr_mag = 3'(mg); hdr_tens = 4'(pt); hdr_units = 4'(pu);
    hdr_hr_tens = 2'(ht); hdr_hr_units = 4'(hu);
    hdr_min_tens = 3'(mt); hdr_min_units = 4'(mu);
    hdr_err = er;
  endtask

  task automatic wcol(input int sl, input int st, input logic [4:0] d);
    set_wr(sl, st, d);
    step();
  endtask

  task automatic judge(input string tag, input logic [7:0] hits);
    int lo = -1;
    for (int s = 7; s >= 0; s--) if (hits[s]) lo = s;
    exp_fn = exp_fn & ~hits;
    chk(tag, "found_pulse", 32'(found_pulse), 32'(lo >= 0));
    if (lo >= 0) begin
      chk(tag, "found_slot", 32'(found_slot), 32'(lo));
      chk(tag, "capture", 32'(capture), 32'(hold_m[lo]));
    end else
      chk(tag, "capture", 32'(capture), 0);
    chk(tag, "found_n", 32'(found_n), 32'(exp_fn));
  endtask

  task automatic hdr(input string tag, input int mg, pt, pu, ht, hu, mt, mu,
                     input logic [6:0] er, input logic [7:0] hits);
    set_hdr(mg, pt, pu, ht, hu, mt, mu, er);
    step();
    judge(tag, hits);
  endtask

  task automatic t_reset();
    chk("R1", "found_n", 32'(found_n), 32'hFF);
    chk("R1", "found_pulse", 32'(found_pulse), 0);
    chk("R1", "capture", 32'(capture), 0);
    // cleared requests care about nothing and are held
    hdr("R3", 5, 1, 2, 0, 0, 0, 0, 7'h00, 8'hFF);
  endtask

  task automatic t_program();
    for (int s = 0; s < 8; s++) wcol(s, 0, {1'b1, 1'b1, 3'(s)});
    chk("R8", "found_n after writes", 32'(found_n), 32'hFF);
    hdr("R9", 5, 0, 0, 0, 0, 0, 0, 7'h00, 8'h20);
  endtask

  task automatic t_page_digits();
    wcol(2, 1, 5'h13);
    wcol(2, -1, 5'h17);
    hdr("R2", 2, 3, 7, 0, 0, 0, 0, 7'h00, 8'h04);
    hdr("R3", 2, 3, 8, 0, 0, 0, 0, 7'h00, 8'h00);
    hdr("R3", 2, 4, 7, 0, 0, 0, 0, 7'h00, 8'h00);
  endtask

  task automatic t_field_width();
    wcol(2, 3, 5'h1E);
    hdr("R4", 2, 3, 7, 2, 0, 0, 0, 7'h00, 8'h04);
    hdr("R4", 2, 3, 7, 3, 0, 0, 0, 7'h00, 8'h00);
  endtask

  task automatic t_pointer_end();
    wcol(0, 6, 5'h19);
    hdr("R2", 0, 0, 0, 0, 0, 0, 9, 7'h00, 8'h01);
    wcol(0, -1, 5'h11);
    chk("R2", "found_n after dropped write", 32'(found_n), 32'(exp_fn));
    hdr("R2", 0, 0, 0, 0, 0, 0, 1, 7'h00, 8'h00);
  endtask

  task automatic t_errors();
    hdr("R5", 5, 0, 0, 0, 0, 0, 0, 7'h01, 8'h00);
    hdr("R5", 5, 0, 0, 0, 0, 0, 0, 7'h40, 8'h20);
    hdr("R5", 2, 3, 7, 2, 0, 0, 0, 7'h02, 8'h00);
  endtask

  task automatic t_hold();
    wcol(4, 0, {1'b1, 1'b0, 3'd4});
    hdr("R7", 4, 0, 0, 0, 0, 0, 0, 7'h00, 8'h10);
  endtask

  task automatic t_subcode();
    wcol(1, 3, 5'h11);
    wcol(1, -1, 5'h12);
    wcol(1, -1, 5'h13);
    wcol(1, -1, 5'h10);
    hdr("R3", 1, 9, 9, 1, 2, 3, 0, 7'h00, 8'h02);
    hdr("R3", 1, 9, 9, 1, 2, 3, 1, 7'h00, 8'h00);
  endtask

  task automatic t_collision();
    hdr("R8", 3, 0, 0, 0, 0, 0, 0, 7'h00, 8'h08);
    set_wr(3, 0, {1'b1, 1'b1, 3'd3});
    set_hdr(3, 0, 0, 0, 0, 0, 0, 7'h00);
    step();
    judge("R8", 8'h00);
    chk("R8", "slot3 flag after collision", 32'(found_n[3]), 1);
  endtask

  task automatic t_wildcard();
    wcol(6, 0, {1'b0, 1'b1, 3'd6});
    hdr("R6", 7, 0, 0, 0, 0, 0, 0, 7'h00, 8'hC0);
    hdr("R5", 5, 0, 0, 0, 0, 0, 0, 7'h01, 8'h40);
  endtask

  task automatic t_idle();
    hdr_mag = 3'd6;
    step();
    chk("R10", "found_pulse", 32'(found_pulse), 0);
    chk("R10", "found_n", 32'(found_n), 32'(exp_fn));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_page_digits();
    t_field_width();
    t_pointer_end();
    t_errors();
    t_hold();
    t_subcode();
    t_collision();
    t_wildcard();
    t_idle();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule